// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical page address. It walks a three-level page table held in memory, reading one 64-bit table entry per level through a port that carries a single request at a time. A request carries the virtual address, the access kind, the root table page number, whether the requester runs in user or supervisor mode, and the two status bits that widen access: one lets supervisor code touch user pages, the other lets loads read execute-only pages.

Each entry it reads is either invalid, a pointer to the next table, or a leaf. A leaf goes through a fixed series of checks, and the block returns either a fault or a page address with read, write and execute grants ready for a TLB fill. On a successful leaf the block sets the accessed flag, and for a store also the dirty flag. It writes the entry back to memory only when one of those flags was not already set.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: A table entry has V at bit 0, R at bit 1, W at bit 2, X at bit 3, U at bit 4, A at bit 6, D at bit 7 and the page number at bits 53:10. The first read goes to `root_ppn`*4096 + vaddr[38:30]*8. An entry with V=1 and R=W=X=0 points to the next table at its page number *4096, indexed by the next 9-bit field of the address (vaddr[29:21], then vaddr[20:12]). The walk makes exactly one read per level it visits.
- R3: An entry with V=0 faults at once, at any level. A pointer entry at the last level also faults.
- R4: A leaf with W=1 and R=0 faults, whatever X holds.
- R5: A leaf with U=1 faults in supervisor mode (`priv_user`=0) when `sum` is 0 or the access is a fetch.
- R6: A leaf with U=0 faults in user mode (`priv_user`=1).
- R7: A leaf found above the last level faults when its page number has any nonzero bit among the low 9 bits (middle level) or the low 18 bits (top level).
- R8: With `req_acc` 0 = load, 1 = store, 2 = fetch: a load needs R=1 or (X=1 and `mxr`=1), a store needs W=1, and a fetch needs X=1. Any other case faults.
- R9: On success `rsp_paddr` = (PPN | (VPN & M)) << 12. Here VPN = vaddr[38:12], and M is 0 at the last level, 0x1FF at the middle level and 0x3FFFF at the top level. The page offset is not included.
- R10: On success `rsp_r` = R | (X & `mxr`), `rsp_x` = X, and `rsp_w` = W & (store | D).
- R11: On success the entry with A set, and D also set on a store, is written to the address it was read from. The write happens only when this changes the entry, and it comes before `rsp_valid`.
- R12: `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. `rsp_valid` lasts one cycle. A fault reports zero address and zero grants. Results do not depend on how many cycles the memory takes to acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when `req_ready` is 1) |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 39 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| root_ppn | input | 44 | Page number of the top-level table |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| sum | input | 1 | Supervisor may access user pages |
| mxr | input | 1 | Loads may read execute-only pages |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 56 | Byte address of the table entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 56 | Physical page address |
| rsp_r | output | 1 | Read granted |
| rsp_w | output | 1 | Write granted |
| rsp_x | output | 1 | Execute granted |

## Verification
The assertions assume that the memory raises `mem_ack` for exactly one cycle per access, only while `mem_req` is high. They also assume that `req_valid` is raised only when the walker is idle and that `req_acc` never holds 3. The bench's memory model counts a configurable number of wait cycles and then acknowledges once, and the next access cannot be acknowledged in the cycle right after. The bench issues requests only between responses, and only with the three defined access codes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WBACK,
    ST_DONE
  } st_e;

  typedef enum logic [2:0] {
    CK_OK,
    CK_INVALID,
    CK_RSVD,
    CK_USER_PG,
    CK_SUPER_PG,
    CK_ALIGN,
    CK_ACCESS
  } cause_e;

  // entry flag positions (fixed by the in-memory table format)
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;
  localparam int PPN_LSB = 10;

  function automatic logic grant_read(input logic [7:0] f, input logic mx);
    return f[B_R] | (f[B_X] & mx);
  endfunction

  function automatic logic grant_write(input logic [7:0] f, input acc_e a);
    return f[B_W] & ((a == ACC_STORE) | f[B_D]);
  endfunction

  function automatic logic access_denied(input logic [7:0] f, input acc_e a, input logic mx);
    case (a)
      ACC_STORE: return !f[B_W];
      ACC_FETCH: return !f[B_X];
      default:   return !grant_read(f, mx);
    endcase
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W     = 39,
  parameter int PA_W     = 56,
  parameter int PPN_W    = 44,
  parameter int SEG_W    = 9,
  parameter int PG_SHIFT = 12,
  parameter int PTE_W    = 64,
  parameter int LVL_W    = 2
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [PPN_W-1:0] leaf_ppn,
  output logic [PA_W-1:0]  pte_addr,
  output logic [PA_W-1:0]  leaf_pa,
  output logic [PPN_W-1:0] span_mask
);
  localparam int PTE_LG = $clog2(PTE_W / 8);
  localparam int VPN_W  = VA_W - PG_SHIFT;

  function automatic logic [SEG_W-1:0] vpn_seg(input logic [VA_W-1:0] v, input logic [LVL_W-1:0] l);
    return v[PG_SHIFT + SEG_W * int'(l) +: SEG_W];
  endfunction

  function automatic logic [PPN_W-1:0] low_span(input logic [LVL_W-1:0] l);
    return ~({PPN_W{1'b1}} << (SEG_W * int'(l)));
  endfunction

  logic [VPN_W-1:0] vpn;
  logic [PPN_W-1:0] vpn_ext;

  assign vpn       = va[VA_W-1:PG_SHIFT];
  assign vpn_ext   = PPN_W'(vpn);
  assign span_mask = low_span(lvl);
  assign pte_addr  = PA_W'({base_ppn, {PG_SHIFT{1'b0}}}) + PA_W'({vpn_seg(va, lvl), {PTE_LG{1'b0}}});
  assign leaf_pa   = PA_W'({(leaf_ppn | (vpn_ext & span_mask)), {PG_SHIFT{1'b0}}});

endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int PPN_W = 44
) (
  input  logic [7:0]       flags,
  input  logic [PPN_W-1:0] ppn,
  input  logic [PPN_W-1:0] span_mask,
  input  acc_e             acc,
  input  logic             user,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_ptr,
  output cause_e           cause,
  output logic             g_r,
  output logic             g_w,
  output logic             g_x,
  output logic [7:0]       flags_upd
);
  logic no_rwx, rsvd, user_bad, super_bad, misaligned, denied;

  assign no_rwx     = !(flags[B_R] | flags[B_W] | flags[B_X]);
  assign is_ptr     = flags[B_V] & no_rwx;
  assign rsvd       = flags[B_W] & !flags[B_R];
  assign user_bad   = flags[B_U] & !user & (!sum | (acc == ACC_FETCH));
  assign super_bad  = !flags[B_U] & user;
  assign misaligned = |(ppn & span_mask);
  assign denied     = access_denied(flags, acc, mxr);

  // ordered check chain; first failing rule names the cause
  always_comb begin
    if (!flags[B_V])     cause = CK_INVALID;
    else if (is_ptr)     cause = CK_OK;
    else if (rsvd)       cause = CK_RSVD;
    else if (user_bad)   cause = CK_USER_PG;
    else if (super_bad)  cause = CK_SUPER_PG;
    else if (misaligned) cause = CK_ALIGN;
    else if (denied)     cause = CK_ACCESS;
    else                 cause = CK_OK;
  end

  assign g_r = grant_read(flags, mxr);
  assign g_w = grant_write(flags, acc);
  assign g_x = flags[B_X];

  always_comb begin
    flags_upd      = flags;
    flags_upd[B_A] = 1'b1;
    if (acc == ACC_STORE) flags_upd[B_D] = 1'b1;
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W     = 39,
  parameter int PA_W     = 56,
  parameter int PPN_W    = 44,
  parameter int LEVELS   = 3,
  parameter int SEG_W    = 9,
  parameter int PG_SHIFT = 12,
  parameter int PTE_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             priv_user,
  input  logic             sum,
  input  logic             mxr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_r,
  output logic             rsp_w,
  output logic             rsp_x
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  st_e              st;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] base;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic             usr_q, sum_q, mxr_q;
  logic [PTE_W-1:0] wdata_q;
  logic             res_fault, res_r, res_w, res_x;
  logic [PA_W-1:0]  res_pa;

  // decoded view of the entry on the read bus
  logic [7:0]       pte_flags, flags_upd;
  logic [PPN_W-1:0] pte_ppn, span_mask;
  logic [PA_W-1:0]  pte_addr, leaf_pa;
  logic             is_ptr, g_r, g_w, g_x;
  cause_e           cause;

  assign pte_flags = mem_rdata[7:0];
  assign pte_ppn   = mem_rdata[PPN_LSB +: PPN_W];

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .SEG_W(SEG_W),
    .PG_SHIFT(PG_SHIFT), .PTE_W(PTE_W), .LVL_W(LVL_W)
  ) u_addr (
    .va(va_q), .lvl(lvl), .base_ppn(base), .leaf_ppn(pte_ppn),
    .pte_addr(pte_addr), .leaf_pa(leaf_pa), .span_mask(span_mask)
  );

  ptw_leaf_check #(.PPN_W(PPN_W)) u_chk_leaf (
    .flags(pte_flags), .ppn(pte_ppn), .span_mask(span_mask),
    .acc(acc_q), .user(usr_q), .sum(sum_q), .mxr(mxr_q),
    .is_ptr(is_ptr), .cause(cause), .g_r(g_r), .g_w(g_w), .g_x(g_x),
    .flags_upd(flags_upd)
  );

  // named walk events
  logic rd_ack, ev_descend, ev_fault, ev_leaf_ok, need_wb;
  assign rd_ack     = (st == ST_READ) && mem_ack;
  assign ev_descend = rd_ack && is_ptr && (lvl != '0);
  assign ev_fault   = rd_ack && ((is_ptr && (lvl == '0)) || (!is_ptr && (cause != CK_OK)));
  assign ev_leaf_ok = rd_ack && !is_ptr && (cause == CK_OK);
  assign need_wb    = flags_upd != pte_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lvl       <= '0;
      base      <= '0;
      va_q      <= '0;
      acc_q     <= ACC_LOAD;
      usr_q     <= 1'b0;
      sum_q     <= 1'b0;
      mxr_q     <= 1'b0;
      wdata_q   <= '0;
      res_fault <= 1'b0;
      res_r     <= 1'b0;
      res_w     <= 1'b0;
      res_x     <= 1'b0;
      res_pa    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          st        <= ST_READ;
          lvl       <= TOP_LVL;
          base      <= root_ppn;
          va_q      <= req_vaddr;
          acc_q     <= acc_e'(req_acc);
          usr_q     <= priv_user;
          sum_q     <= sum;
          mxr_q     <= mxr;
          res_fault <= 1'b0;
          res_r     <= 1'b0;
          res_w     <= 1'b0;
          res_x     <= 1'b0;
          res_pa    <= '0;
        end
        ST_READ: begin
          if (ev_descend) begin
            base <= pte_ppn;
            lvl  <= lvl - 1'b1;
          end
          if (ev_fault) begin
            res_fault <= 1'b1;
            st        <= ST_DONE;
          end
          if (ev_leaf_ok) begin
            res_pa <= leaf_pa;
            res_r  <= g_r;
            res_w  <= g_w;
            res_x  <= g_x;
            if (need_wb) begin
              wdata_q <= {mem_rdata[PTE_W-1:8], flags_upd};
              st      <= ST_WBACK;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_WBACK: if (mem_ack) st <= ST_DONE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_READ) || (st == ST_WBACK);
  assign mem_we    = (st == ST_WBACK);
  assign mem_addr  = pte_addr;
  assign mem_wdata = wdata_q;
  assign rsp_valid = (st == ST_DONE);
  assign rsp_fault = res_fault;
  assign rsp_paddr = res_pa;
  assign rsp_r     = res_r;
  assign rsp_w     = res_w;
  assign rsp_x     = res_x;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [PA_W-1:0]  mem_addr,
  input logic [PTE_W-1:0] mem_wdata,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_r,
  input logic             rsp_w,
  input logic             rsp_x,
  input logic             ev_descend,
  input logic             ev_leaf_ok
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);

  p_descend_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |=> mem_req && !mem_we);

  p_wb_sets_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[6]);

  p_wb_after_leaf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(ev_leaf_ok));

  p_hold_until_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_fault_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_paddr == '0) && !rsp_r && !rsp_w && !rsp_x);

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_walker_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x),
  .ev_descend(ev_descend), .ev_leaf_ok(ev_leaf_ok)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [38:0] req_vaddr;
  logic [1:0]  req_acc;
  logic [43:0] root_ppn;
  logic        priv_user, sum, mxr;
  logic        mem_req, mem_we;
  logic [55:0] mem_addr;
  logic [63:0] mem_wdata;
  bit          mem_ack;
  logic [63:0] mem_rdata;
  logic        rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [55:0] rsp_paddr;

  always #4 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .root_ppn(root_ppn),
    .priv_user(priv_user), .sum(sum), .mxr(mxr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x)
  );

  // memory model: small word array, backdoor port, configurable latency
  logic [63:0] pmem [0:2047];
  int          lat = 1;
  int          wait_cnt = 0;
  int          nrd = 0;
  int          nwr = 0;
  logic [55:0] last_rd = '0;
  bit          bd_we;
  logic [10:0] bd_idx;
  logic [63:0] bd_dat;

  always @(posedge clk) begin
    if (bd_we) pmem[bd_idx] <= bd_dat;
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt + 1 >= lat) begin
        wait_cnt <= 0;
        mem_ack  <= 1'b1;
        if (mem_we) begin
          pmem[mem_addr[13:3]] <= mem_wdata;
          nwr <= nwr + 1;
        end else begin
          mem_rdata <= pmem[mem_addr[13:3]];
          nrd       <= nrd + 1;
          last_rd   <= mem_addr;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  typedef struct packed {
    logic [23:0] tag;
    logic [1:0]  lvl;
    logic [7:0]  flg;
    logic [43:0] ppn;
    logic [1:0]  acc;
    logic        usr, sm, mx;
    logic        f, r, w, x, wb;
  } vec_t;

  localparam int NV = 21;
  // flags: D7 A6 U4 X3 W2 R1 V0 ; acc 0 load 1 store 2 fetch
  localparam vec_t VEC [NV] = '{
    '{"R10", 2'd0, 8'hC7, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{"R11", 2'd0, 8'h07, 44'h12345, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{"R10", 2'd0, 8'h07, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{"R8 ", 2'd0, 8'h09, 44'h12345, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{"R8 ", 2'd0, 8'h09, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R8 ", 2'd0, 8'h09, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R4 ", 2'd0, 8'h05, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R4 ", 2'd0, 8'h0D, 44'h12345, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R5 ", 2'd0, 8'h13, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R5 ", 2'd0, 8'h13, 44'h12345, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{"R5 ", 2'd0, 8'h19, 44'h12345, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R6 ", 2'd0, 8'h13, 44'h12345, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{"R6 ", 2'd0, 8'h03, 44'h12345, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R9 ", 2'd1, 8'h43, 44'h12200, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{"R7 ", 2'd1, 8'h43, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R9 ", 2'd2, 8'h43, 44'h40000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{"R7 ", 2'd2, 8'h43, 44'h40100, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R3 ", 2'd0, 8'h06, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R8 ", 2'd0, 8'h03, 44'h12345, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R3 ", 2'd0, 8'h01, 44'h12345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R11", 2'd0, 8'hC7, 44'h12345, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  // VA fields: top 1, middle 2, last 3, offset abc
  localparam logic [38:0] VA = {9'd1, 9'd2, 9'd3, 12'habc};

  int checks = 0;
  int failures = 0;
  logic        o_fault, o_r, o_w, o_x;
  logic [55:0] o_pa;

  task automatic check(input bit ok, input logic [23:0] tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input logic [10:0] idx, input logic [63:0] dat);
    @(negedge clk);
    bd_we  = 1'b1;
    bd_idx = idx;
    bd_dat = dat;
    @(negedge clk);
    bd_we  = 1'b0;
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] p, input logic [7:0] f);
    return {10'b0, p, 2'b00, f};
  endfunction

  function automatic logic [10:0] leaf_idx(input logic [1:0] l);
    case (l)
      2'd2:    return 11'h201;
      2'd1:    return 11'h402;
      default: return 11'h603;
    endcase
  endfunction

  function automatic logic [55:0] exp_pa(input logic [1:0] l, input logic [43:0] p);
    case (l)
      2'd2:    return {p | {26'b0, VA[29:12]}, 12'h000};
      2'd1:    return {p | {35'b0, VA[20:12]}, 12'h000};
      default: return {p, 12'h000};
    endcase
  endfunction

  task automatic build(input logic [1:0] l, input logic [63:0] leaf);
    if (l == 2'd2) poke(11'h201, leaf);
    else poke(11'h201, mk_pte(44'd2, 8'h01));
    if (l == 2'd1) poke(11'h402, leaf);
    else if (l == 2'd0) poke(11'h402, mk_pte(44'd3, 8'h01));
    if (l == 2'd0) poke(11'h603, leaf);
  endtask

  task automatic walk(input logic [1:0] acc, input logic usr, input logic sm, input logic mx);
    int guard;
    @(negedge clk);
    req_vaddr = VA; req_acc = acc; root_ppn = 44'd1;
    priv_user = usr; sum = sm; mxr = mx; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    check(rsp_valid, "R12", "response arrived", 64'(rsp_valid), 64'd1);
    o_fault = rsp_fault; o_pa = rsp_paddr; o_r = rsp_r; o_w = rsp_w; o_x = rsp_x;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R12", "single-cycle response", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; root_ppn = '0;
    priv_user = 1'b0; sum = 1'b0; mxr = 1'b0; bd_we = 1'b0; bd_idx = '0; bd_dat = '0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    check(req_ready === 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    check(mem_req === 1'b0, "R1", "mem_req in reset", 64'(mem_req), 64'd0);
    check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && mem_req === 1'b0, "R1", "idle after reset", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int rd0, wr0;
      logic [63:0] leaf, upd;
      v    = VEC[i];
      leaf = mk_pte(v.ppn, v.flg);
      build(v.lvl, leaf);
      rd0 = nrd; wr0 = nwr;
      walk(v.acc, v.usr, v.sm, v.mx);
      check(o_fault == v.f, v.tag, "fault flag", 64'(o_fault), 64'(v.f));
      if (!v.f) begin
        check(o_pa == exp_pa(v.lvl, v.ppn), "R9", "page address", 64'(o_pa), 64'(exp_pa(v.lvl, v.ppn)));
        check({o_r, o_w, o_x} == {v.r, v.w, v.x}, "R10", "grants rwx", 64'({o_r, o_w, o_x}), 64'({v.r, v.w, v.x}));
      end else begin
        check(o_pa == '0 && {o_r, o_w, o_x} == 3'b000, "R12", "fault clears result", 64'(o_pa), 64'd0);
      end
      // R2: one read per visited level, last read at the leaf slot
      check(nrd - rd0 == 3 - int'(v.lvl), "R2", "read count", 64'(nrd - rd0), 64'(3 - int'(v.lvl)));
      check(last_rd == {45'b0, leaf_idx(v.lvl)} << 3, "R2", "last read address", 64'(last_rd), 64'({leaf_idx(v.lvl), 3'b000}));
      // R11: write-back only when flags change
      check(nwr - wr0 == int'(v.wb), "R11", "write count", 64'(nwr - wr0), 64'(v.wb));
      upd = v.wb ? (leaf | 64'h40 | (v.acc == 2'd1 ? 64'h80 : 64'h0)) : leaf;
      check(pmem[leaf_idx(v.lvl)] == upd, "R11", "entry in memory", pmem[leaf_idx(v.lvl)], upd);
    end

    // R3: invalid entry at the top level stops after one read
    begin
      int rd0;
      poke(11'h201, 64'h0);
      rd0 = nrd;
      walk(2'd0, 1'b0, 1'b0, 1'b0);
      check(o_fault == 1'b1, "R3", "invalid top entry", 64'(o_fault), 64'd1);
      check(nrd - rd0 == 1, "R3", "reads on invalid top", 64'(nrd - rd0), 64'd1);
    end

    // R12: slow memory gives the same store result and write-back
    begin
      int wr0;
      logic [63:0] leaf;
      lat  = 4;
      leaf = mk_pte(44'h12345, 8'h07);
      build(2'd0, leaf);
      wr0 = nwr;
      walk(2'd1, 1'b0, 1'b0, 1'b0);
      check(o_fault == 1'b0 && o_w == 1'b1, "R12", "slow memory store", 64'({o_fault, o_w}), 64'b01);
      check(o_pa == {44'h12345, 12'h000}, "R12", "slow memory address", 64'(o_pa), 64'({44'h12345, 12'h000}));
      check(nwr - wr0 == 1 && pmem[11'h603] == (leaf | 64'hC0), "R12", "slow memory write-back",
            pmem[11'h603], leaf | 64'hC0);
      lat = 1;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule